// File: doc/BRIEF.md
# Raw Sample Capture Sequencer

This block sequences the capture of an unformatted sample stream. On each rising clock edge it accepts one sample when the external capture qualifier is high, the software enable is set and the sequencer is in its running state. Accepted samples are counted against a block length built from two 12-bit fields. Each time a programmed number of samples has arrived, the block sends a one-cycle transfer request to a downstream mover. The data path and the mover are not part of this block; it produces only the timing and control events.

When the last sample of a block is accepted, a sticky frame-done flag is raised. What happens next depends on the repeat mode. Continuous mode keeps capturing. Noncontinuous mode captures one further block and stops if software has not cleared the flag by the end of it. Single mode stops at once until the flag is cleared. An optional sync gate holds capture after enabling or re-arming until a sync pulse arrives. A second sticky flag records overrun, which is a transfer request raised while the previous one is still unacknowledged. Both flags clear on a write of one and drive interrupt outputs through their own enable bits.

Top module: `rawcap_seq`

## Requirements
- R1: The block length is the 24-bit value {size_hi, size_lo}. When the accepted-sample count reaches this value, stat_frm is set (visible after that edge), and both the sample counter and the threshold counter restart at zero for the next block.
- R2: A sample is accepted only on a rising edge where cap_en=1, sw_en=1 and capturing=1. With sw_en=0, cap_en has no effect on xfer_req or stat_frm.
- R3: xfer_req is a one-cycle pulse, high in the cycle after the edge that accepts the thresh-th sample since the previous request or since block start. thresh=0 produces no requests.
- R4: irq_cmp = stat_frm AND ie_cmp, and irq_ovr = stat_ovr AND ie_ovr.
- R5: Continuous mode (rpt_mode=2'b00): capturing stays 1 across block ends, and the next block is accepted from the next qualified edge.
- R6: Noncontinuous mode (rpt_mode=2'b01): at a block end, capture stops (capturing=0) if stat_frm was already set and was not cleared on that edge. Otherwise capture continues.
- R7: Single mode (rpt_mode=2'b10, and also 2'b11): capture stops at each block end. While stopped, cap_en is ignored. The sequencer re-arms one cycle after stat_frm reads 0.
- R8: With sync_en=1, after sw_en rises and after each re-arm in single or noncontinuous mode, capturing stays 0 until a cycle with sync_in=1. capturing becomes 1 after that edge.
- R9: stat_ovr sets when a transfer request fires while the previous request is unacknowledged, meaning xfer_ack has not been high in any cycle since that request, including the current cycle.
- R10: stat_clr is write-one-to-clear, with bit 0 clearing stat_frm and bit 1 clearing stat_ovr. If a set and a clear of the same flag fall on one edge, the flag stays set.
- R11: Dropping sw_en sets capturing=0 on the next edge and discards any partial block, so the count restarts from zero. Both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | External capture qualifier |
| sw_en | input | 1 | Software capture enable |
| rpt_mode | input | 2 | 00 continuous, 01 noncontinuous, 10/11 single |
| size_lo | input | 12 | Low 12 bits of the block length |
| size_hi | input | 12 | High 12 bits of the block length |
| thresh | input | 12 | Samples per transfer request, 0 disables requests |
| sync_en | input | 1 | Require a sync pulse before capturing |
| sync_in | input | 1 | Sync pulse |
| xfer_ack | input | 1 | Acknowledge of the outstanding transfer request |
| ie_cmp | input | 1 | Completion interrupt enable |
| ie_ovr | input | 1 | Overrun interrupt enable |
| stat_clr | input | 2 | Write-one-to-clear strobes, bit0 frame, bit1 overrun |
| xfer_req | output | 1 | Transfer request pulse |
| capturing | output | 1 | Sequencer is in its running state |
| stat_frm | output | 1 | Sticky frame-done flag |
| stat_ovr | output | 1 | Sticky overrun flag |
| irq_cmp | output | 1 | Completion interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
The collisions that matter occur when a block end or a transfer request falls on the same edge as a software clear of the flag it sets. The bench drives stat_clr in exactly the cycle that accepts the last sample of a block, and in the cycle whose sample triggers an overrun. It then expects the flag to remain set. A second collision is the noncontinuous stop decision: clearing stat_frm partway through the second block must keep capture running, and leaving it set must halt capture. The bench judges this from capturing and from the absence of further requests.

// File: rtl/rawcap_pkg.sv
package rawcap_pkg;

  typedef enum logic [1:0] {
    RPT_CONT    = 2'b00,
    RPT_NONCONT = 2'b01,
    RPT_SINGLE  = 2'b10
  } rpt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WSYNC = 2'b01,
    ST_RUN   = 2'b10,
    ST_HALT  = 2'b11
  } seq_st_e;

  localparam int FLG_FRM = 0;
  localparam int FLG_OVR = 1;
  localparam int N_FLG   = 2;

endpackage

// File: rtl/rawcap_cnt.sv
module rawcap_cnt #(
  parameter int FIELD_W = 12,
  parameter int THR_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               acc,
  input  logic [FIELD_W-1:0] size_lo,
  input  logic [FIELD_W-1:0] size_hi,
  input  logic [THR_W-1:0]   thresh,
  output logic               blk_hit,
  output logic               thr_hit
);
  localparam int CNT_W = 2 * FIELD_W;

  logic [CNT_W-1:0] smp_q;
  logic [THR_W-1:0] thr_q;

  function automatic logic [CNT_W-1:0] join_size(input logic [FIELD_W-1:0] hi,
                                                 input logic [FIELD_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic is_last(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] len);
    return (cnt + CNT_W'(1)) == len;
  endfunction

  function automatic logic thr_due(input logic [THR_W-1:0] cnt,
                                   input logic [THR_W-1:0] lim);
    return (lim != '0) && ((cnt + THR_W'(1)) == lim);
  endfunction

  assign blk_hit = acc && is_last(smp_q, join_size(size_hi, size_lo));
  assign thr_hit = acc && thr_due(thr_q, thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      thr_q <= '0;
    end else if (restart) begin
      smp_q <= '0;
      thr_q <= '0;
    end else if (acc) begin
      if (blk_hit) begin
        smp_q <= '0;
        thr_q <= '0;
      end else begin
        smp_q <= smp_q + CNT_W'(1);
        thr_q <= thr_hit ? '0 : thr_q + THR_W'(1);
      end
    end
  end

  AST_NO_COUNT_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !blk_hit || (join_size(size_hi, size_lo) == CNT_W'(1))); // R11

endmodule

// File: rtl/rawcap_ctl.sv
module rawcap_ctl
  import rawcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_en,
  input  logic [1:0] rpt_mode,
  input  logic       sync_en,
  input  logic       sync_in,
  input  logic       blk_hit,
  input  logic       frm_q,
  input  logic       clr_frm,
  output logic       run
);
  seq_st_e st_q, st_d;
  logic    is_cont, is_nc;

  assign is_cont = (rpt_mode == RPT_CONT);
  assign is_nc   = (rpt_mode == RPT_NONCONT);

  function automatic seq_st_e arm_state(input logic need_sync);
    return need_sync ? ST_WSYNC : ST_RUN;
  endfunction

  always_comb begin
    st_d = st_q;
    if (!sw_en) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = arm_state(sync_en);
        ST_WSYNC: if (sync_in) st_d = ST_RUN;
        ST_RUN: begin
          if (blk_hit) begin
            if (is_cont)     st_d = ST_RUN;
            else if (is_nc)  st_d = (frm_q && !clr_frm) ? ST_HALT : ST_RUN;
            else             st_d = ST_HALT;
          end
        end
        ST_HALT:  if (!frm_q) st_d = arm_state(sync_en);
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign run = (st_q == ST_RUN);

  AST_SINGLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_hit && !is_cont && !is_nc) |=> st_q == ST_HALT); // R7
  AST_CONT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_hit && is_cont) |=> st_q == ST_RUN); // R5
  AST_WSYNC_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WSYNC && !sync_in) |=> st_q != ST_RUN); // R8

endmodule

// File: rtl/rawcap_stat.sv
module rawcap_stat
  import rawcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_hit,
  input  logic             thr_hit,
  input  logic             xfer_ack,
  input  logic [N_FLG-1:0] clr,
  input  logic             ie_cmp,
  input  logic             ie_ovr,
  output logic             xfer_req,
  output logic             frm_q,
  output logic             ovr_q,
  output logic             irq_cmp,
  output logic             irq_ovr
);
  logic             pend_q;
  logic             ovr_set;
  logic [N_FLG-1:0] flg_set, flg_q;

  assign ovr_set = thr_hit && pend_q && !xfer_ack;

  always_comb begin
    flg_set          = '0;
    flg_set[FLG_FRM] = blk_hit;
    flg_set[FLG_OVR] = ovr_set;
  end

  for (genvar g = 0; g < N_FLG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flg_q[g] <= 1'b0;
      else if (flg_set[g]) flg_q[g] <= 1'b1;
      else if (clr[g])     flg_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      xfer_req <= 1'b0;
    end else begin
      pend_q   <= thr_hit || (pend_q && !xfer_ack);
      xfer_req <= thr_hit;
    end
  end

  assign frm_q   = flg_q[FLG_FRM];
  assign ovr_q   = flg_q[FLG_OVR];
  assign irq_cmp = frm_q && ie_cmp;
  assign irq_ovr = ovr_q && ie_ovr;

  AST_FRM_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hit |=> frm_q); // R10
  AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(pend_q)); // R9

endmodule

// File: rtl/rawcap_seq.sv
module rawcap_seq
  import rawcap_pkg::*;
#(
  parameter int FIELD_W = 12,
  parameter int THR_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               sw_en,
  input  logic [1:0]         rpt_mode,
  input  logic [FIELD_W-1:0] size_lo,
  input  logic [FIELD_W-1:0] size_hi,
  input  logic [THR_W-1:0]   thresh,
  input  logic               sync_en,
  input  logic               sync_in,
  input  logic               xfer_ack,
  input  logic               ie_cmp,
  input  logic               ie_ovr,
  input  logic [1:0]         stat_clr,
  output logic               xfer_req,
  output logic               capturing,
  output logic               stat_frm,
  output logic               stat_ovr,
  output logic               irq_cmp,
  output logic               irq_ovr
);
  logic run, accept, blk_hit, thr_hit;

  assign accept    = cap_en && sw_en && run;
  assign capturing = run;

  rawcap_cnt #(.FIELD_W(FIELD_W), .THR_W(THR_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (!sw_en),
    .acc     (accept),
    .size_lo (size_lo),
    .size_hi (size_hi),
    .thresh  (thresh),
    .blk_hit (blk_hit),
    .thr_hit (thr_hit)
  );

  rawcap_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_en    (sw_en),
    .rpt_mode (rpt_mode),
    .sync_en  (sync_en),
    .sync_in  (sync_in),
    .blk_hit  (blk_hit),
    .frm_q    (stat_frm),
    .clr_frm  (stat_clr[FLG_FRM]),
    .run      (run)
  );

  rawcap_stat u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_hit  (blk_hit),
    .thr_hit  (thr_hit),
    .xfer_ack (xfer_ack),
    .clr      (stat_clr),
    .ie_cmp   (ie_cmp),
    .ie_ovr   (ie_ovr),
    .xfer_req (xfer_req),
    .frm_q    (stat_frm),
    .ovr_q    (stat_ovr),
    .irq_cmp  (irq_cmp),
    .irq_ovr  (irq_ovr)
  );

  AST_XFER_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> $past(accept)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && $past(!sw_en)) |-> !xfer_req); // R2

endmodule

// File: tb/rawcap_seq_test.sv
module rawcap_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cap_en, sw_en, sync_en, sync_in, xfer_ack, ie_cmp, ie_ovr;
  logic [1:0]  rpt_mode, stat_clr;
  logic [11:0] size_lo, size_hi, thresh;
  logic xfer_req, capturing, stat_frm, stat_ovr, irq_cmp, irq_ovr;

  rawcap_seq uut (.*);

  int n_chk = 0, n_fail = 0;
  int m_s, m_t, m_sz, m_th;
  bit m_frm, m_ev;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic feed(input int n, output int pulses);
    pulses = 0;
    cap_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      step();
      pulses += int'(xfer_req);
    end
    cap_en = 1'b0;
  endtask

  task automatic reset_cfg();
    sw_en = 1'b0; cap_en = 1'b0; stat_clr = 2'b11;
    step();
    stat_clr = 2'b00;
  endtask

  task automatic start();
    sw_en = 1'b1; cap_en = 1'b0;
    step();
  endtask

  task automatic model_acc();
    m_ev = 1'b0;
    m_s++; m_t++;
    if (m_th != 0 && m_t == m_th) begin m_ev = 1'b1; m_t = 0; end
    if (m_s == m_sz) begin m_frm = 1'b1; m_s = 0; m_t = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int p;
    rst_n = 0; cap_en = 0; sw_en = 0; sync_en = 0; sync_in = 0; xfer_ack = 0;
    ie_cmp = 0; ie_ovr = 0; rpt_mode = 2'b00; stat_clr = 0;
    size_lo = 12'd2; size_hi = 0; thresh = 12'd1;
    repeat (3) step();
    rst_n = 1;
    step();
    check("R2", "reset xfer_req", xfer_req, 0);
    check("R2", "reset capturing", capturing, 0);
    check("R1", "reset stat_frm", stat_frm, 0);
    check("R9", "reset stat_ovr", stat_ovr, 0);
    check("R4", "reset irqs", int'(irq_cmp | irq_ovr), 0);

    // R2: enable low, qualifier high
    cap_en = 1;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R2", "xfer_req with sw_en=0", xfer_req, 0);
    end
    check("R2", "stat_frm with sw_en=0", stat_frm, 0);
    cap_en = 0;

    // R1/R3/R5 sweep in continuous mode
    xfer_ack = 1;
    for (int sz = 1; sz <= 6; sz++) begin
      for (int th = 0; th <= 4; th++) begin
        reset_cfg();
        rpt_mode = 2'b00; size_hi = 0; size_lo = 12'(sz); thresh = 12'(th);
        start();
        m_s = 0; m_t = 0; m_sz = sz; m_th = th; m_frm = 0;
        for (int i = 0; i < 3 * sz + 5; i++) begin
          cap_en = (((i * 7 + th) % 4) != 0);
          m_ev = 0;
          if (cap_en) model_acc();
          step();
          check("R3", "sweep xfer_req", xfer_req, int'(m_ev));
          check("R1", "sweep stat_frm", stat_frm, int'(m_frm));
          check("R5", "sweep capturing", capturing, 1);
        end
        cap_en = 0;
      end
    end

    // R1: high field of the length
    reset_cfg();
    size_hi = 12'd1; size_lo = 12'd0; thresh = 0;
    start();
    feed(4095, p);
    check("R1", "frm after 4095 of 4096", stat_frm, 0);
    feed(1, p);
    check("R1", "frm after 4096 of 4096", stat_frm, 1);

    // R4: interrupt gating
    ie_cmp = 0; step();
    check("R4", "irq_cmp disabled", irq_cmp, 0);
    ie_cmp = 1; step();
    check("R4", "irq_cmp enabled", irq_cmp, 1);

    // R10: block end and clear on one edge
    reset_cfg();
    size_hi = 0; size_lo = 12'd3; thresh = 0;
    start();
    feed(2, p);
    cap_en = 1; stat_clr = 2'b01; step(); cap_en = 0; stat_clr = 2'b00;
    check("R10", "frm set beats clear", stat_frm, 1);
    stat_clr = 2'b01; step(); stat_clr = 2'b00;
    check("R10", "frm cleared by W1C", stat_frm, 0);

    // R9: overrun
    reset_cfg();
    xfer_ack = 0; ie_ovr = 1; size_lo = 12'd100; thresh = 12'd2;
    start();
    feed(2, p);
    check("R3", "first request", p, 1);
    check("R9", "no overrun on first", stat_ovr, 0);
    feed(2, p);
    check("R9", "overrun on unacked second", stat_ovr, 1);
    check("R4", "irq_ovr", irq_ovr, 1);
    stat_clr = 2'b10; step(); stat_clr = 2'b00;
    check("R10", "ovr cleared", stat_ovr, 0);
    xfer_ack = 1; step(); xfer_ack = 0;
    feed(2, p);
    check("R9", "no overrun after ack", stat_ovr, 0);
    feed(1, p);
    cap_en = 1; stat_clr = 2'b10; step(); cap_en = 0; stat_clr = 2'b00;
    check("R10", "ovr set beats clear", stat_ovr, 1);
    xfer_ack = 1; ie_ovr = 0;

    // R7: single mode
    reset_cfg();
    rpt_mode = 2'b10; size_lo = 12'd4; thresh = 12'd4;
    start();
    feed(4, p);
    check("R7", "single first block request", p, 1);
    check("R7", "single frm", stat_frm, 1);
    check("R7", "single stopped", capturing, 0);
    feed(6, p);
    check("R7", "no requests while stopped", p, 0);
    stat_clr = 2'b01; step(); stat_clr = 2'b00;
    step();
    check("R7", "single re-armed", capturing, 1);
    feed(4, p);
    check("R7", "single second block", int'(stat_frm) + p, 2);

    // R6: noncontinuous mode
    reset_cfg();
    rpt_mode = 2'b01;
    start();
    feed(4, p);
    check("R6", "nc first block keeps running", capturing, 1);
    feed(4, p);
    check("R6", "nc second block request", p, 1);
    check("R6", "nc stop with flag uncleared", capturing, 0);
    feed(3, p);
    check("R6", "nc no requests while stopped", p, 0);
    stat_clr = 2'b01; step(); stat_clr = 2'b00;
    step();
    check("R6", "nc re-armed", capturing, 1);
    feed(4, p);
    check("R6", "nc runs on with flag clear", capturing, 1);
    feed(2, p);
    stat_clr = 2'b01; step(); stat_clr = 2'b00;
    feed(2, p);
    check("R6", "nc flag cleared mid-block", capturing, 1);
    check("R6", "nc flag set again", stat_frm, 1);

    // R8: sync gate
    reset_cfg();
    rpt_mode = 2'b10; sync_en = 1; size_lo = 12'd2; thresh = 12'd1;
    start();
    check("R8", "waiting for sync", capturing, 0);
    feed(3, p);
    check("R8", "no requests before sync", p, 0);
    sync_in = 1; step(); sync_in = 0;
    check("R8", "running after sync", capturing, 1);
    feed(2, p);
    check("R8", "requests after sync", p, 2);
    stat_clr = 2'b01; step(); stat_clr = 2'b00;
    step();
    check("R8", "re-arm waits for sync", capturing, 0);
    feed(2, p);
    check("R8", "no requests before second sync", p, 0);
    sync_in = 1; step(); sync_in = 0;
    check("R8", "running after second sync", capturing, 1);
    sync_en = 0;

    // R11: dropping the enable discards a partial block
    reset_cfg();
    rpt_mode = 2'b00; size_lo = 12'd4; thresh = 0;
    start();
    feed(2, p);
    sw_en = 0; cap_en = 1; step(); cap_en = 0;
    check("R11", "idle after enable drop", capturing, 0);
    start();
    feed(3, p);
    check("R11", "count restarted", stat_frm, 0);
    feed(1, p);
    check("R11", "full block after restart", stat_frm, 1);
    sw_en = 0; step();
    check("R11", "flag kept while disabled", stat_frm, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule